// File: doc/BRIEF.md
# Page-Buffered Timed Write Commit Unit

This unit sits between a two-wire bus protocol engine and a 128 x 8 storage array. The engine hands over each received write data byte with its column inside the current page. The unit keeps the byte in an 8-slot page latch and sets a valid flag for that slot. The page row is captured when the engine signals a new write address phase. The unit does not handle bus signalling.

When the engine reports a stop condition and at least one slot is valid, the unit starts a self-timed commit. It raises `busy` for a fixed, parameterised number of clock cycles. During the first cycles of that window it walks the eight slots and copies only the valid ones into the array row. Slots that were not received keep their old contents. A high write-protect input at the stop suppresses the commit entirely. A start condition before the stop, or a stop with nothing latched, throws the latch away. While `busy` is high every other input is ignored. A combinational read port exposes the array to the read path.

Top module: `pwc_commit_unit`

## Requirements
- R1: The array holds 16 rows of 8 bytes and is read combinationally at word address `rd_addr = {row[3:0], col[2:0]}`. Every byte reads 0 after reset, and `busy` is 0 after reset.
- R2: A `byte_vld` strobe stores `byte_data` in latch slot `byte_col` and marks that slot valid. A later strobe to the same column in the same transaction replaces the earlier byte, so a ninth or later byte overwrites its wrapped slot.
- R3: A commit writes exactly the valid slots into the latched row. All other bytes of that row, and all other rows, keep their values.
- R4: A commit starts only on a `stop_evt` with at least one valid slot, `wp` low and `busy` low. `busy` rises on the next clock and stays high for exactly `WRITE_CYCLES` cycles.
- R5: With `wp` high at the stop, no byte of the array changes and `busy` stays low. Bytes are still accepted before the stop, and the latch is discarded at the stop.
- R6: A `start_evt` before the stop discards the latch, and the following stop then starts no commit. A stop with no valid slot starts no commit.
- R7: An `addr_phase` pulse loads the row from `row_addr` and clears all valid flags, so only bytes received after it are committed.
- R8: While `busy` is high, `byte_vld`, `addr_phase`, `start_evt` and `stop_evt` are ignored.
- R9: Valid flags are cleared when a commit completes. A later stop with no new byte starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_phase | input | 1 | Pulse: new write address phase, row taken from row_addr |
| row_addr | input | 4 | Page row for the transaction |
| byte_vld | input | 1 | Pulse: one write data byte received |
| byte_col | input | 3 | Column of the received byte |
| byte_data | input | 8 | Received byte |
| start_evt | input | 1 | Pulse: start condition seen on the bus |
| stop_evt | input | 1 | Pulse: stop condition seen on the bus |
| wp | input | 1 | Write protect, high protects the whole array |
| busy | output | 1 | Self-timed commit in progress |
| rd_addr | input | 7 | Read word address {row, col} |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The assertions check on every cycle that the array is written only while `busy` is high and never from a protected stop. They also check that each busy window lasts exactly `WRITE_CYCLES` cycles and that busy rises only right after a stop. Other properties are visible only through the bench's scenarios: which bytes land in the array, the wrapped overwrite of a long page write, and the discarding of a latch by start, address phase or write protect. The same holds for the inputs ignored during busy. The bench compares these against a reference page model over directed and seeded random transactions.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int unsigned ROW_BITS_DEF   = 4;
    localparam int unsigned COL_BITS_DEF   = 3;
    localparam int unsigned DATA_W_DEF     = 8;
    localparam int unsigned WRITE_CYC_DEF  = 40;

    // Action taken on the page latch in one cycle, highest priority first.
    typedef enum logic [1:0] {
        LA_HOLD  = 2'd0,
        LA_CLEAR = 2'd1,
        LA_ADDR  = 2'd2,
        LA_BYTE  = 2'd3
    } latch_act_e;
endpackage

// File: rtl/pwc_page_latch.sv
module pwc_page_latch
    import pwc_pkg::*;
#(
    parameter int unsigned ROW_BITS = ROW_BITS_DEF,
    parameter int unsigned COL_BITS = COL_BITS_DEF,
    parameter int unsigned DATA_W   = DATA_W_DEF,
    localparam int unsigned SLOTS   = 1 << COL_BITS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  latch_act_e                       act,
    input  logic [ROW_BITS-1:0]              row_in,
    input  logic [COL_BITS-1:0]              col_in,
    input  logic [DATA_W-1:0]                data_in,
    output logic [ROW_BITS-1:0]              row_out,
    output logic [SLOTS-1:0]                 valid_out,
    output logic [SLOTS-1:0][DATA_W-1:0]     data_out
);
    typedef struct packed {
        logic [ROW_BITS-1:0]          row;
        logic [SLOTS-1:0]             valid;
        logic [SLOTS-1:0][DATA_W-1:0] data;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act)
            LA_CLEAR: st_d.valid = '0;
            LA_ADDR: begin
                st_d.valid = '0;
                st_d.row   = row_in;
            end
            LA_BYTE: begin
                st_d.data[col_in]  = data_in;
                st_d.valid[col_in] = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_out   = st_q.row;
    assign valid_out = st_q.valid;
    assign data_out  = st_q.data;
endmodule

// File: rtl/pwc_write_timer.sv
module pwc_write_timer #(
    parameter int unsigned WRITE_CYCLES = pwc_pkg::WRITE_CYC_DEF,
    parameter int unsigned COL_BITS     = pwc_pkg::COL_BITS_DEF,
    localparam int unsigned CW          = $clog2(WRITE_CYCLES + 1),
    localparam int unsigned SLOTS       = 1 << COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    output logic                busy,
    output logic                done,
    output logic                scan_on,
    output logic [COL_BITS-1:0] scan_idx
);
    localparam logic [CW-1:0] WC = CW'(WRITE_CYCLES);
    localparam logic [CW-1:0] NS = CW'(SLOTS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CW-1:0] elapsed;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        else if (go)        st_d.cnt = WC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = (st_q.cnt != '0);
    assign done     = (st_q.cnt == CW'(1));
    assign elapsed  = WC - st_q.cnt;
    assign scan_on  = busy && (elapsed < NS);
    assign scan_idx = elapsed[COL_BITS-1:0];
endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pwc_commit_unit.sv
module pwc_commit_unit
    import pwc_pkg::*;
#(
    parameter int unsigned ROW_BITS     = ROW_BITS_DEF,
    parameter int unsigned COL_BITS     = COL_BITS_DEF,
    parameter int unsigned DATA_W       = DATA_W_DEF,
    parameter int unsigned WRITE_CYCLES = WRITE_CYC_DEF,
    localparam int unsigned ADDR_W      = ROW_BITS + COL_BITS,
    localparam int unsigned SLOTS       = 1 << COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_phase,
    input  logic [ROW_BITS-1:0] row_addr,
    input  logic                byte_vld,
    input  logic [COL_BITS-1:0] byte_col,
    input  logic [DATA_W-1:0]   byte_data,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                wp,
    output logic                busy,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data
);
    logic [ROW_BITS-1:0]          lat_row;
    logic [SLOTS-1:0]             lat_valid;
    logic [SLOTS-1:0][DATA_W-1:0] lat_data;
    logic                         tmr_done;
    logic                         scan_on;
    logic [COL_BITS-1:0]          scan_idx;
    logic                         commit_go;
    latch_act_e                   act;
    logic                         arr_we;
    logic [ADDR_W-1:0]            arr_waddr;

    // Bus events only count while idle; a commit is launched from a stop
    // that finds something latched and protection off.
    always_comb begin
        commit_go = 1'b0;
        act       = LA_HOLD;
        if (busy) begin
            if (tmr_done) act = LA_CLEAR;
        end else if (start_evt) begin
            act = LA_CLEAR;
        end else if (stop_evt) begin
            act       = LA_CLEAR;
            commit_go = (lat_valid != '0) && !wp;
            if (commit_go) act = LA_HOLD;
        end else if (addr_phase) begin
            act = LA_ADDR;
        end else if (byte_vld) begin
            act = LA_BYTE;
        end
    end

    pwc_page_latch #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DATA_W   (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .row_in    (row_addr),
        .col_in    (byte_col),
        .data_in   (byte_data),
        .row_out   (lat_row),
        .valid_out (lat_valid),
        .data_out  (lat_data)
    );

    pwc_write_timer #(
        .WRITE_CYCLES (WRITE_CYCLES),
        .COL_BITS     (COL_BITS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (commit_go),
        .busy     (busy),
        .done     (tmr_done),
        .scan_on  (scan_on),
        .scan_idx (scan_idx)
    );

    assign arr_we    = scan_on && lat_valid[scan_idx];
    assign arr_waddr = {lat_row, scan_idx};

    pwc_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (lat_data[scan_idx]),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    initial begin
        if (WRITE_CYCLES < SLOTS)
            $error("WRITE_CYCLES must cover one slot per cycle");
    end
endmodule

// File: rtl/pwc_commit_checker.sv
module pwc_commit_checker #(
    parameter int unsigned WRITE_CYCLES = pwc_pkg::WRITE_CYC_DEF
) (
    input logic clk,
    input logic rst_n,
    input logic stop_evt,
    input logic wp,
    input logic busy,
    input logic arr_we
);
    localparam int unsigned RW = $clog2(WRITE_CYCLES + 2);
    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R3: the array port is used only inside a commit window
    p_write_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R4: a busy window opens only right after a stop
    p_busy_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R4: each window lasts exactly WRITE_CYCLES cycles
    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RW'(WRITE_CYCLES)));

    p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RW'(WRITE_CYCLES)));

    // R5: a protected stop from idle never opens a window
    p_wp_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && wp && !busy) |=> !busy);
endmodule

bind pwc_commit_unit pwc_commit_checker #(
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_evt (stop_evt),
    .wp       (wp),
    .busy     (busy),
    .arr_we   (arr_we)
);

// File: tb/pwc_commit_unit_tb.sv
`timescale 1ns/1ps
module pwc_commit_unit_tb;
    localparam int WC = 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_phase = 1'b0;
    logic [3:0] row_addr = '0;
    logic       byte_vld = 1'b0;
    logic [2:0] byte_col = '0;
    logic [7:0] byte_data = '0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       wp = 1'b0;
    logic       busy;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] ref_mem [128];
    logic [7:0] m_data [8];
    logic       m_valid [8];
    logic [3:0] m_row;

    always #2.5 clk = ~clk;

    pwc_commit_unit #(.WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .row_addr(row_addr),
        .byte_vld(byte_vld), .byte_col(byte_col), .byte_data(byte_data),
        .start_evt(start_evt), .stop_evt(stop_evt), .wp(wp), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [6:0] waddr(input logic [3:0] r, input logic [2:0] c);
        return {r, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_clear();
        for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
    endtask

    task automatic do_addr(input logic [3:0] r);
        @(negedge clk); addr_phase = 1'b1; row_addr = r;
        @(negedge clk); addr_phase = 1'b0;
        if (!busy) begin m_clear(); m_row = r; end
    endtask

    task automatic do_byte(input logic [2:0] c, input logic [7:0] d);
        @(negedge clk); byte_vld = 1'b1; byte_col = c; byte_data = d;
        @(negedge clk); byte_vld = 1'b0;
        if (!busy) begin m_data[c] = d; m_valid[c] = 1'b1; end
    endtask

    task automatic do_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
        m_clear();
    endtask

    // Pulses stop; returns how many cycles busy was then seen high.
    task automatic do_stop(output int blen, output bit expect_commit);
        bit any = 1'b0;
        for (int i = 0; i < 8; i++) any |= m_valid[i];
        expect_commit = any && !wp;
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        blen = 0;
        while (busy && blen < 10000) begin
            blen++;
            @(negedge clk);
        end
        if (expect_commit)
            for (int i = 0; i < 8; i++)
                if (m_valid[i]) ref_mem[waddr(m_row, 3'(i))] = m_data[i];
        m_clear();
    endtask

    task automatic check_row(input string req, input logic [3:0] r);
        for (int i = 0; i < 8; i++) begin
            rd_addr = waddr(r, 3'(i));
            #1;
            chk(req, rd_data, ref_mem[rd_addr]);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 128; i++) begin
            rd_addr = 7'(i);
            #1;
            if (rd_data !== ref_mem[i]) chk(req, rd_data, ref_mem[i]);
        end
        chk({req, " sweep"}, 32'd1, 32'd1);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int  blen;
        bit  ec;
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
        m_clear();
        m_row = '0;
        for (int i = 0; i < 8; i++) m_data[i] = '0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy after reset", busy, 0);
        check_all("R1 reset contents");
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: partial page of 3 bytes into row 5
        do_addr(4'd5);
        do_byte(3'd2, 8'hA1);
        do_byte(3'd3, 8'hB2);
        do_byte(3'd4, 8'hC3);
        do_stop(blen, ec);
        chk("R4 busy length", blen, WC);
        check_row("R3 partial page row5", 4'd5);
        check_all("R3 other rows");

        // R2: 10 bytes from column 6 wrap and overwrite cols 6,7
        do_addr(4'd9);
        for (int k = 0; k < 10; k++) do_byte(3'(6 + k), 8'(8'h10 + k));
        do_stop(blen, ec);
        chk("R4 busy length page", blen, WC);
        rd_addr = waddr(4'd9, 3'd6); #1;
        chk("R2 wrap overwrite col6", rd_data, 8'h18);
        rd_addr = waddr(4'd9, 3'd7); #1;
        chk("R2 wrap overwrite col7", rd_data, 8'h19);
        check_row("R2 row9", 4'd9);

        // R5: write protect
        wp = 1'b1;
        do_addr(4'd5);
        do_byte(3'd0, 8'hEE);
        do_byte(3'd3, 8'hEF);
        do_stop(blen, ec);
        chk("R5 no busy under wp", blen, 0);
        wp = 1'b0;
        check_row("R5 row unchanged", 4'd5);
        do_stop(blen, ec);
        chk("R5 latch discarded", blen, 0);

        // R6: start before stop discards; empty stop
        do_addr(4'd2);
        do_byte(3'd1, 8'h55);
        do_start();
        do_stop(blen, ec);
        chk("R6 start discards", blen, 0);
        check_row("R6 row2 unchanged", 4'd2);
        do_addr(4'd2);
        do_stop(blen, ec);
        chk("R6 empty stop", blen, 0);

        // R7: second address phase clears earlier bytes
        do_addr(4'd3);
        do_byte(3'd0, 8'h77);
        do_byte(3'd1, 8'h78);
        do_addr(4'd4);
        do_byte(3'd5, 8'h79);
        do_stop(blen, ec);
        chk("R7 commit after readdress", blen, WC);
        check_row("R7 row3 untouched", 4'd3);
        check_row("R7 row4 one byte", 4'd4);

        // R8/R9: inputs during busy ignored, flags cleared after commit
        do_addr(4'd6);
        do_byte(3'd0, 8'h31);
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        for (int i = 0; i < 8; i++) if (m_valid[i]) ref_mem[waddr(m_row, 3'(i))] = m_data[i];
        m_clear();
        chk("R8 busy during commit", busy, 1);
        @(negedge clk); addr_phase = 1'b1; row_addr = 4'd7;
        @(negedge clk); addr_phase = 1'b0; byte_vld = 1'b1; byte_col = 3'd2; byte_data = 8'h99;
        @(negedge clk); byte_vld = 1'b0; start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0; stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        blen = 5;
        while (busy) begin blen++; @(negedge clk); end
        chk("R8 stop in busy no extension", blen, WC);
        do_stop(blen, ec);
        chk("R9 flags cleared after commit", blen, 0);
        check_row("R8 row6", 4'd6);
        check_row("R8 row7 untouched", 4'd7);

        // Random transactions
        for (int t = 0; t < 12; t++) begin
            logic [3:0] r;
            logic [2:0] c0;
            int n;
            r  = 4'($urandom_range(0, 15));
            c0 = 3'($urandom_range(0, 7));
            n  = $urandom_range(1, 12);
            wp = ($urandom_range(0, 3) == 0);
            do_addr(r);
            for (int k = 0; k < n; k++) do_byte(3'(c0 + k), 8'($urandom));
            do_stop(blen, ec);
            chk(ec ? "R4 random busy" : "R5 random wp busy", blen, ec ? WC : 0);
            wp = 1'b0;
            check_row("R3 random row", r);
        end
        check_all("R3 final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule